// File: doc/BRIEF.md
# Programmable Divide-by-N Counter

This block is a synchronous frequency divider. It produces one output pulse for every N rising edges of its clock. The ratio N is set by a sixteen-bit jam bus holding four binary-coded nibbles and by a three-bit mode selector. The mode picks the modulus of a fast first section (10, 8, 5, 4 or 2). The jam value is not a plain binary count. It is split into three parts: a residue for the first section, three decimal digits for a chain of decade sections, and a small top digit. The top digit comes from the spare upper bits of the lowest nibble that the residue does not use.

Every section counts down. When the whole chain reaches its terminal state, recognition logic reloads every section from the jam bus and raises the output for one clock. A preset control forces a reload on every edge and holds the output low, so the divider can be started at a known phase. A latch control freezes the output while the counter keeps running.

Top module: `prog_ratio_divider`

## Requirements
- R1: With the sections loaded as D1 (residue), D2..D4 (decades from jam[7:4], jam[11:8], jam[15:12], bit 0 of each nibble the least significant) and D5 (top digit), the interval between output pulses is N = M·(1000·D5 + 100·D4 + 10·D3 + D2) + D1, where M is the first-section modulus.
- R2: mode_sel selects M and the top-digit range L as follows: 3'b000 gives M=10, L=1; 3'b001 gives M=8, L=2; 3'b101 gives M=5, L=2; 3'b011 gives M=4, L=4; 3'b111 gives M=2, L=8.
- R3: Any mode_sel code not listed in R2 (3'b010, 3'b100, 3'b110) behaves as 3'b000.
- R4: D1 is taken from the low bits of jam[3:0] (4 bits for M=10, 3 for M=8 and M=5, 2 for M=4, 1 for M=2). A D1 above M−1 loads as M−1, and a decade nibble above 9 loads as 9.
- R5: D5 is taken from the bits of jam[3:0] above the residue bits, so its range is 0..L−1; it is zero for M=10.
- R6: For N of at least 2, div_out is high for exactly one clock per period, and successive rising edges of div_out are N clocks apart.
- R7: While preset_en is high, every section reloads from the jam bus on each edge and div_out is low on the next cycle. The first pulse appears N edges after the last edge with preset_en high.
- R8: A ratio that works out to 0 or 1 behaves as N=1: div_out stays high on every cycle.
- R9: While latch_en is high (and preset_en low), div_out keeps its value. The count continues, so pulse phase is kept across the hold.
- R10: A synchronous active-low reset clears div_out and every section. The first edge after reset, with preset_en and latch_en low, loads the jam value and raises div_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock being divided |
| rst_n | input | 1 | Synchronous active-low reset |
| jam | input | 16 | Ratio preset: residue and top digit in [3:0], decades in [7:4], [11:8], [15:12] |
| mode_sel | input | 3 | First-section modulus select |
| preset_en | input | 1 | Forces a reload on every edge and holds the output low |
| latch_en | input | 1 | Freezes the output value |
| div_out | output | 1 | Divided output, one clock high per period |

## Verification
On every cycle, the embedded assertions check the following. Every section stays inside its digit range. The top section never borrows, which would mean the chain has counted below zero. A terminal count with both controls low raises the output on the next cycle. Preset forces the output low. Latch freezes the output. Only the bench's scenarios can show that the spacing between pulses equals the ratio given by the formula for each mode, including the clamping of out-of-range digits, the placement of the top digit, the unlisted mode codes and the degenerate ratios. The same holds for keeping the pulse phase across a latch hold.

// File: rtl/divn_pkg.sv
// Package: shared constants and the mode decoder for the divide-by-N counter.
// Assumes four-bit jam nibbles and at most eight top-digit values.
package divn_pkg;

    localparam int NIB_W = 4;   // width of one jam nibble / digit
    localparam int TOP_W = 3;   // width of the top section (values 0..7)
    localparam int RES_W = 3;   // width of the residue bit count

    typedef struct packed {
        logic [NIB_W-1:0] first_mod;  // first-section modulus
        logic [NIB_W-1:0] last_mod;   // number of top-digit values
        logic [RES_W-1:0] res_bits;   // jam[3:0] bits used by the residue
    } mode_cfg_t;

    // Maps the mode code to first modulus, top range and residue width.
    function automatic mode_cfg_t decode_mode(input logic [2:0] sel);
        mode_cfg_t c;
        case (sel)
            3'b001:  c = '{first_mod: 4'd8, last_mod: 4'd2, res_bits: 3'd3};
            3'b101:  c = '{first_mod: 4'd5, last_mod: 4'd2, res_bits: 3'd3};
            3'b011:  c = '{first_mod: 4'd4, last_mod: 4'd4, res_bits: 3'd2};
            3'b111:  c = '{first_mod: 4'd2, last_mod: 4'd8, res_bits: 3'd1};
            default: c = '{first_mod: 4'd10, last_mod: 4'd1, res_bits: 3'd4};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/divn_digit.sv
// Module: one down-counting section of the divider chain.
// Loads a clamped preset, or steps down by one and wraps to its limit,
// raising borrow when it wraps. Assumes limit never exceeds MAX_VAL.
module divn_digit #(
    parameter int W       = 4,
    parameter int MAX_VAL = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] limit,
    output logic [W-1:0] value,
    output logic         borrow
);

    logic [W-1:0] val_q;
    logic [W-1:0] ld_clamped;

    // Clamp an out-of-range preset to the section's largest value.
    always_comb begin
        ld_clamped = (load_val > limit) ? limit : load_val;
    end

    // Section state: reset, reload or count down with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
        end else if (load) begin
            val_q <= ld_clamped;
        end else if (step) begin
            val_q <= (val_q == '0) ? limit : val_q - 1'b1;
        end
    end

    assign value  = val_q;
    assign borrow = step && (val_q == '0);

    // R4: a section never holds a value above its digit range.
    a_r4_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
        val_q <= W'(MAX_VAL));

endmodule

// File: rtl/divn_recognize.sv
// Module: terminal-count recognition for the divider chain.
// The chain is terminal when every upper section is zero and the
// first section holds 0 or 1; this covers both N=1 and the reset state.
module divn_recognize #(
    parameter int W    = 4,
    parameter int N_UP = 4
) (
    input  logic [W-1:0]    first_val,
    input  logic [N_UP-1:0] upper_zero,
    output logic            term
);

    // Combine the per-section zero flags with the first-section test.
    always_comb begin
        term = (first_val <= W'(1)) && (&upper_zero);
    end

endmodule

// File: rtl/prog_ratio_divider.sv
// Module: programmable divide-by-N counter (top).
// Chain: a mode-selected first section, NUM_MID decade sections and a
// top section, all counting down. Terminal count reloads the chain from
// the jam bus and raises div_out for one clock. preset_en reloads every
// edge and holds div_out low; latch_en freezes div_out.
module prog_ratio_divider
    import divn_pkg::*;
#(
    parameter int NUM_MID = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [(NUM_MID+1)*NIB_W-1:0] jam,
    input  logic [2:0]                   mode_sel,
    input  logic                         preset_en,
    input  logic                         latch_en,
    output logic                         div_out
);

    localparam int NUM_DIG = NUM_MID + 2;

    mode_cfg_t          cfg;
    logic [NIB_W:0]     one_shift;
    logic [NIB_W-1:0]   res_mask;
    logic [NIB_W-1:0]   first_ld;
    logic [NIB_W-1:0]   first_lim;
    logic [NIB_W-1:0]   first_val;
    logic [TOP_W-1:0]   top_ld;
    logic [TOP_W-1:0]   top_lim;
    logic [NUM_DIG-1:0] step_c;
    logic [NUM_DIG-2:0] upper_zero;
    logic               top_borrow;
    logic               load;
    logic               term;
    logic               out_q;

    // Decode the mode and split the low nibble into residue and top digit.
    always_comb begin
        cfg       = decode_mode(mode_sel);
        one_shift = {{NIB_W{1'b0}}, 1'b1} << cfg.res_bits;
        res_mask  = NIB_W'(one_shift - 1'b1);
        first_ld  = jam[NIB_W-1:0] & res_mask;
        top_ld    = TOP_W'(jam[NIB_W-1:0] >> cfg.res_bits);
        first_lim = cfg.first_mod - 1'b1;
        top_lim   = TOP_W'(cfg.last_mod - 1'b1);
    end

    assign load      = preset_en | term;
    assign step_c[0] = ~load;

    // Build the section chain; the position picks the section variant.
    for (genvar g = 0; g < NUM_DIG; g++) begin : g_sec
        if (g == 0) begin : g_first
            logic [NIB_W-1:0] v;
            logic             b;
            divn_digit #(.W(NIB_W), .MAX_VAL(9)) u_sec (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (load),
                .step     (step_c[0]),
                .load_val (first_ld),
                .limit    (first_lim),
                .value    (v),
                .borrow   (b)
            );
            assign first_val = v;
            assign step_c[1] = b;
        end else if (g == NUM_DIG - 1) begin : g_top
            logic [TOP_W-1:0] v;
            logic             b;
            divn_digit #(.W(TOP_W), .MAX_VAL(7)) u_sec (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (load),
                .step     (step_c[g]),
                .load_val (top_ld),
                .limit    (top_lim),
                .value    (v),
                .borrow   (b)
            );
            assign upper_zero[g-1] = (v == '0);
            assign top_borrow      = b;
        end else begin : g_mid
            logic [NIB_W-1:0] v;
            logic             b;
            divn_digit #(.W(NIB_W), .MAX_VAL(9)) u_sec (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (load),
                .step     (step_c[g]),
                .load_val (jam[g*NIB_W +: NIB_W]),
                .limit    (NIB_W'(9)),
                .value    (v),
                .borrow   (b)
            );
            assign upper_zero[g-1] = (v == '0);
            assign step_c[g+1]     = b;
        end
    end

    divn_recognize #(.W(NIB_W), .N_UP(NUM_DIG-1)) u_recog (
        .first_val  (first_val),
        .upper_zero (upper_zero),
        .term       (term)
    );

    // Output stage: low under preset, held under latch, else the terminal flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else if (preset_en) begin
            out_q <= 1'b0;
        end else if (!latch_en) begin
            out_q <= term;
        end
    end

    assign div_out = out_q;

    // R6: the chain never counts below zero.
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        !top_borrow);

    // R6: a recognised terminal count shows on the output next cycle.
    a_r6_terminal_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (term && !preset_en && !latch_en) |=> div_out);

    // R7: preset holds the output low.
    a_r7_preset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        preset_en |=> !div_out);

    // R9: latch freezes the output.
    a_r9_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en && !preset_en) |=> $stable(div_out));

endmodule

// File: tb/tb_prog_ratio_divider.sv
// Directed bench for prog_ratio_divider: one task per scenario.
module tb_prog_ratio_divider;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] jam = '0;
    logic [2:0]  mode_sel = 3'b000;
    logic        preset_en = 1'b0;
    logic        latch_en = 1'b0;
    logic        div_out;

    int tests = 0;
    int fails = 0;

    prog_ratio_divider dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .jam       (jam),
        .mode_sel  (mode_sel),
        .preset_en (preset_en),
        .latch_en  (latch_en),
        .div_out   (div_out)
    );

    always #4 clk = ~clk;  // 125 MHz

    task automatic check(input string req, input int act, input int exp, input string what);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected ratio from the requirements (R1-style formula, R2..R5, R8).
    function automatic int exp_ratio(input logic [2:0] m, input logic [15:0] j);
        int md, rb, d1, d5, d2, d3, d4, n;
        case (m)
            3'b001:  begin md = 8;  rb = 3; end
            3'b101:  begin md = 5;  rb = 3; end
            3'b011:  begin md = 4;  rb = 2; end
            3'b111:  begin md = 2;  rb = 1; end
            default: begin md = 10; rb = 4; end
        endcase
        d1 = int'(j[3:0]) % (1 << rb);
        if (d1 > md - 1) d1 = md - 1;
        d5 = int'(j[3:0]) >> rb;
        d2 = (j[7:4]   > 9) ? 9 : int'(j[7:4]);
        d3 = (j[11:8]  > 9) ? 9 : int'(j[11:8]);
        d4 = (j[15:12] > 9) ? 9 : int'(j[15:12]);
        n  = md * (1000 * d5 + 100 * d4 + 10 * d3 + d2) + d1;
        return (n < 1) ? 1 : n;
    endfunction

    // Count negedges until div_out is seen high.
    task automatic wait_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!div_out && n < 40000);
    endtask

    // Preset, release, and check the first interval (and optionally the next).
    task automatic run_ratio(input string req, input logic [2:0] m, input logic [15:0] j, input bit again);
        int exp, n;
        exp = exp_ratio(m, j);
        @(negedge clk);
        mode_sel = m; jam = j; preset_en = 1'b1;
        @(negedge clk);
        check("R7", int'(div_out), 0, "output under preset");
        preset_en = 1'b0;
        wait_pulse(n);
        check(req, n, exp, "first interval");
        if (exp > 1) begin
            @(negedge clk);
            check("R6", int'(div_out), 0, "pulse width");
            if (again) begin
                wait_pulse(n);
                check("R6", n + 1, exp, "second interval");
            end
        end
    endtask

    task automatic t_reset;
        check("R10", int'(div_out), 0, "output in reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", int'(div_out), 1, "first edge after reset");
    endtask

    task automatic t_unity(input logic [15:0] j, input logic [2:0] m);
        @(negedge clk);
        mode_sel = m; jam = j; preset_en = 1'b1;
        @(negedge clk);
        preset_en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R8", int'(div_out), 1, "degenerate ratio high");
        end
    endtask

    task automatic t_latch;
        int n;
        @(negedge clk);
        mode_sel = 3'b011; jam = 16'h0023; preset_en = 1'b1;  // N = 11
        @(negedge clk);
        preset_en = 1'b0; latch_en = 1'b1;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            check("R9", int'(div_out), 0, "held during latch");
        end
        latch_en = 1'b0;
        wait_pulse(n);
        check("R9", n + 15, 22, "phase kept across latch");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        run_ratio("R1", 3'b101, 16'h695C, 1'b1);  // 8479, D5=1 from jam[3]
        run_ratio("R2", 3'b000, 16'h0237, 1'b1);  // 237
        run_ratio("R5", 3'b001, 16'h002D, 1'b0);  // 8021
        run_ratio("R5", 3'b011, 16'h001E, 1'b0);  // 12006
        run_ratio("R5", 3'b111, 16'h000F, 1'b0);  // 14001
        run_ratio("R4", 3'b000, 16'h00AC, 1'b1);  // clamps to 99
        run_ratio("R4", 3'b101, 16'h0007, 1'b1);  // clamps to 4
        run_ratio("R3", 3'b010, 16'h0023, 1'b1);  // 23
        run_ratio("R3", 3'b110, 16'h0015, 1'b0);  // 15
        run_ratio("R6", 3'b111, 16'h0010, 1'b1);  // 2
        t_unity(16'h0001, 3'b111);
        t_unity(16'h0000, 3'b000);
        t_latch();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule